// File: doc/BRIEF.md
# Serial Command Front End for a Sixteen-Channel Low-Side Switch

This block is the digital control path of a sixteen-channel low-side switch. A host reaches it over a four-wire serial link. The host pulls chip select low and clocks data in most significant bit first. The block samples the data line on each rising serial clock edge. It updates the return line after each falling edge, which is clock phase/polarity mode 0.

When a frame starts, the shift register loads a 24-bit status word that carries the filtered per-channel open-load faults. The host therefore reads the faults while it writes the next command. The command takes effect only when chip select returns high, and only if the frame held a whole number of 24-bit words. With a 48-bit frame, the first word clocked in comes back out during the second half. The host compares it with what it sent to confirm the link. The word still in the register when chip select rises becomes the command.

The low 16 bits of the command set the channel output enables. The next bit turns on the open-load pulldown. The block gates each channel's raw open-load comparator flag: a fault is reported only while that channel is off and the pulldown is on. After any change of that channel's output bit, the flag is blanked for a set number of system clocks. All serial pins are resynchronised into the single system clock domain. The system clock must run several times faster than the serial clock.

Top module: `lsd_spi_ctrl`

## Requirements
- R1: `out_en` changes only as the result of a rising edge on `cs_n` that ends a frame of 24 or 48 serial clocks. It then takes bits [15:0] of the word held in the shift register at that moment. It never changes while bits are being shifted.
- R2: The first 24 bits returned on `miso_d` in a frame form the status word {8'b0, fault_flags[15:0]}, captured when `cs_n` falls, most significant bit first. Each bit is valid before the rising `sclk` edge on which the host samples it, and the next bit follows each falling edge.
- R3: `miso_oe` is 1 during a frame and 0 while `cs_n` is high.
- R4: In a 48-bit frame, the last 24 bits returned equal the first 24 bits sent. The second 24 bits sent are the ones latched.
- R5: After reset, `out_en` is 0, `pd_en` is 0, `fault_flags` is 0 and `miso_oe` is 0.
- R6: `pd_en` takes bit 16 of the latched word and becomes 1 only through such a write. Bits [23:17] have no effect on any output.
- R7: While `sleep` is 1, `pd_en` is forced to 0 and `out_en` is left unchanged.
- R8: A frame whose clock count is 0 or is not a multiple of 24 leaves `out_en` and `pd_en` unchanged.
- R9: In steady state, `fault_flags[i]` = `raw_open[i]` AND NOT `out_en[i]` AND `pd_en`.
- R10: When a write changes `out_en[i]`, `fault_flags[i]` is held at 0 for 16 system clocks (BLANK_CYC) after the update. It then follows R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Sleep mode request; clears the pulldown enable |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| mosi | input | 1 | Serial data from host |
| miso_d | output | 1 | Serial data to host |
| miso_oe | output | 1 | Drive enable for the return line pad |
| raw_open | input | 16 | Raw per-channel open-load comparator flags |
| out_en | output | 16 | Channel output enables |
| pd_en | output | 1 | Open-load pulldown enable |
| fault_flags | output | 16 | Gated, blanked open-load faults |

## Verification
Frames of 24 and 48 bits carry random command words with random reserved bits. Checking them against a reference model separates the echo path from the latch path, and confirms that the second word is the one applied. Truncated and overlong frames of 1, 23, 25, 36 and 47 bits must leave the outputs unchanged. They expose a counter that only looks at wrap-around or latches every frame. Random comparator patterns combined with random output and pulldown states are read back both through the status word and through the fault port, which tests the gating in both directions. A directed turn-off of a faulty channel separates correct blanking from none, and sleep pulses separate a pulldown clear from a full register clear.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  localparam int unsigned DEF_CH      = 16;
  localparam int unsigned DEF_FRAME_W = 24;
  localparam int unsigned DEF_BLANK   = 16;
  localparam int unsigned DEF_SYNC    = 2;

  // one-clock event flags decoded from the resynchronised serial pins
  typedef struct packed {
    logic clk_rise;
    logic clk_fall;
    logic sel_fall;
    logic sel_rise;
  } spi_evt_t;
endpackage

// File: rtl/lsd_sync.sv
module lsd_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= INIT;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/lsd_shifter.sv
module lsd_shifter
  import lsd_pkg::*;
#(
  parameter int unsigned FRAME_W = DEF_FRAME_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_s,
  input  logic               cs_s,
  input  logic               mosi_s,
  input  logic [FRAME_W-1:0] status,
  output logic               miso_d,
  output logic               miso_oe,
  output logic               latch_stb,
  output logic [FRAME_W-1:0] latch_word
);
  localparam int unsigned CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic               sclk_q, cs_q;
  spi_evt_t           evt;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bit_cnt;
  logic               word_seen;
  logic               miso_q;

  always_comb begin
    evt.clk_rise = sclk_s & ~sclk_q;
    evt.clk_fall = ~sclk_s & sclk_q;
    evt.sel_fall = ~cs_s & cs_q;
    evt.sel_rise = cs_s & ~cs_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= 1'b0;
      cs_q      <= 1'b1;
      shreg     <= '0;
      bit_cnt   <= '0;
      word_seen <= 1'b0;
      miso_q    <= 1'b0;
      miso_oe   <= 1'b0;
    end else begin
      sclk_q  <= sclk_s;
      cs_q    <= cs_s;
      miso_oe <= ~cs_s;
      if (evt.sel_fall) begin
        shreg     <= status;
        miso_q    <= status[FRAME_W-1];
        bit_cnt   <= '0;
        word_seen <= 1'b0;
      end else if (!cs_s && evt.clk_rise) begin
        shreg <= {shreg[FRAME_W-2:0], mosi_s};
        if (bit_cnt == LAST) begin
          bit_cnt   <= '0;
          word_seen <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (!cs_s && evt.clk_fall) begin
        miso_q <= shreg[FRAME_W-1];
      end
    end
  end

  // a strobe marks a frame of whole words only
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_stb  <= 1'b0;
      latch_word <= '0;
    end else begin
      latch_stb  <= evt.sel_rise & word_seen & (bit_cnt == '0);
      latch_word <= shreg;
    end
  end

  assign miso_d = miso_q;
endmodule

// File: rtl/lsd_cmd_regs.sv
module lsd_cmd_regs
  import lsd_pkg::*;
#(
  parameter int unsigned CH      = DEF_CH,
  parameter int unsigned FRAME_W = DEF_FRAME_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sleep,
  input  logic               latch_stb,
  input  logic [FRAME_W-1:0] latch_word,
  output logic [CH-1:0]      out_en,
  output logic               pd_en,
  output logic [CH-1:0]      chg_mask
);
  localparam int unsigned PD_BIT = CH;

  // channels whose enable flips on this strobe, aligned with the update
  assign chg_mask = latch_stb ? (latch_word[CH-1:0] ^ out_en) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_en <= '0;
      pd_en  <= 1'b0;
    end else begin
      if (latch_stb) out_en <= latch_word[CH-1:0];
      if (sleep)          pd_en <= 1'b0;
      else if (latch_stb) pd_en <= latch_word[PD_BIT];
    end
  end
endmodule

// File: rtl/lsd_fault_filter.sv
module lsd_fault_filter
  import lsd_pkg::*;
#(
  parameter int unsigned CH        = DEF_CH,
  parameter int unsigned BLANK_CYC = DEF_BLANK
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CH-1:0] raw_s,
  input  logic [CH-1:0] out_en,
  input  logic          pd_en,
  input  logic [CH-1:0] chg_mask,
  output logic [CH-1:0] fault_flags
);
  localparam int unsigned CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(BLANK_CYC);

  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic [CW-1:0] blank_cnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        blank_cnt      <= '0;
        fault_flags[i] <= 1'b0;
      end else begin
        if (chg_mask[i])          blank_cnt <= LOAD;
        else if (blank_cnt != '0) blank_cnt <= blank_cnt - 1'b1;
        fault_flags[i] <= raw_s[i] & ~out_en[i] & pd_en & (blank_cnt == '0);
      end
    end
  end
endmodule

// File: rtl/lsd_spi_ctrl.sv
module lsd_spi_ctrl
  import lsd_pkg::*;
#(
  parameter int unsigned CH          = DEF_CH,
  parameter int unsigned FRAME_W     = DEF_FRAME_W,
  parameter int unsigned BLANK_CYC   = DEF_BLANK,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          mosi,
  output logic          miso_d,
  output logic          miso_oe,
  input  logic [CH-1:0] raw_open,
  output logic [CH-1:0] out_en,
  output logic          pd_en,
  output logic [CH-1:0] fault_flags
);
  localparam int unsigned PAD_W = FRAME_W - CH;

  logic [2:0]         pins_s;
  logic [CH-1:0]      raw_s;
  logic               latch_stb;
  logic [FRAME_W-1:0] latch_word;
  logic [CH-1:0]      chg_mask;
  logic [FRAME_W-1:0] status;

  assign status = {{PAD_W{1'b0}}, fault_flags};

  lsd_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) pin_sync_i (
    .clk(clk), .rst(rst), .d({cs_n, sclk, mosi}), .q(pins_s)
  );

  lsd_sync #(.W(CH), .STAGES(SYNC_STAGES), .INIT('0)) raw_sync_i (
    .clk(clk), .rst(rst), .d(raw_open), .q(raw_s)
  );

  lsd_shifter #(.FRAME_W(FRAME_W)) shifter_i (
    .clk(clk), .rst(rst),
    .sclk_s(pins_s[1]), .cs_s(pins_s[2]), .mosi_s(pins_s[0]),
    .status(status), .miso_d(miso_d), .miso_oe(miso_oe),
    .latch_stb(latch_stb), .latch_word(latch_word)
  );

  lsd_cmd_regs #(.CH(CH), .FRAME_W(FRAME_W)) cmd_i (
    .clk(clk), .rst(rst), .sleep(sleep),
    .latch_stb(latch_stb), .latch_word(latch_word),
    .out_en(out_en), .pd_en(pd_en), .chg_mask(chg_mask)
  );

  lsd_fault_filter #(.CH(CH), .BLANK_CYC(BLANK_CYC)) filter_i (
    .clk(clk), .rst(rst), .raw_s(raw_s), .out_en(out_en), .pd_en(pd_en),
    .chg_mask(chg_mask), .fault_flags(fault_flags)
  );
endmodule

// File: rtl/lsd_spi_ctrl_chk.sv
module lsd_spi_ctrl_chk #(
  parameter int unsigned CH = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          sleep,
  input logic          miso_oe,
  input logic          pd_en,
  input logic [CH-1:0] out_en,
  input logic [CH-1:0] fault_flags,
  input logic          latch_stb
);
  // R1: enables move only on a frame strobe
  a_r1_latch_only: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_en) |-> $past(latch_stb));

  // R6: pulldown turns on only through a write
  a_r6_pd_write: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_en) |-> $past(latch_stb));

  // R7: sleep clears the pulldown
  a_r7_sleep_clr: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !pd_en);

  // R3: pad released when select is idle
  a_r3_oe_idle: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso_oe);

  for (genvar i = 0; i < CH; i++) begin : g_chan
    // R9: a fault implies channel off and pulldown on
    a_r9_gate: assert property (@(posedge clk) disable iff (rst)
      fault_flags[i] |-> (!$past(out_en[i]) && $past(pd_en)));
    // R10: no fault right after a channel's enable flips
    a_r10_blank: assert property (@(posedge clk) disable iff (rst)
      !$stable(out_en[i]) |=> !fault_flags[i]);
  end
endmodule

bind lsd_spi_ctrl lsd_spi_ctrl_chk #(.CH(CH)) chk_i (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sleep(sleep), .miso_oe(miso_oe),
  .pd_en(pd_en), .out_en(out_en), .fault_flags(fault_flags),
  .latch_stb(latch_stb)
);

// File: tb/lsd_spi_ctrl_tb_top.sv
`timescale 1ns/1ps
module lsd_spi_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sleep = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        mosi = 1'b0;
  logic        miso_d, miso_oe;
  logic [15:0] raw_open = '0;
  logic [15:0] out_en, fault_flags;
  logic        pd_en;

  int n_tests = 0;
  int n_fail  = 0;

  logic [15:0] out_m = '0;
  logic        pd_m  = 1'b0;
  logic        oe_mid;

  always #10 clk = ~clk;

  lsd_spi_ctrl dut_i (
    .clk(clk), .rst(rst), .sleep(sleep), .cs_n(cs_n), .sclk(sclk),
    .mosi(mosi), .miso_d(miso_d), .miso_oe(miso_oe), .raw_open(raw_open),
    .out_en(out_en), .pd_en(pd_en), .fault_flags(fault_flags)
  );

  function automatic logic [15:0] fexp(logic [15:0] raw, logic [15:0] o, logic pd);
    return raw & ~o & {16{pd}};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [47:0] act,
                       input logic [47:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // sends tx[47] first; returns the returned bits in the same positions
  task automatic spi_xfer(input logic [47:0] tx, input int n, output logic [47:0] rx);
    rx = '0;
    cs_n = 1'b0;
    wait_clk(8);
    for (int k = 0; k < n; k++) begin
      mosi = tx[47-k];
      wait_clk(6);
      rx[47-k] = miso_d;
      if (k == 0) oe_mid = miso_oe;
      sclk = 1'b1;
      wait_clk(6);
      sclk = 1'b0;
    end
    wait_clk(6);
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  // full frame with all checks against the model
  task automatic frame(input logic [47:0] tx, input int n);
    logic [47:0] rx, st, mask;
    logic [23:0] w;
    st   = {8'h00, fexp(raw_open, out_m, pd_m), 24'h0};
    mask = ~(48'hFFFF_FFFF_FFFF >> n);
    spi_xfer(tx, n, rx);
    check((rx & mask & {24'hFFFFFF, 24'h0}) == (st & mask), "R2 status word",
          rx & mask, st & mask);
    check(oe_mid == 1'b1, "R3 oe in frame", 48'(oe_mid), 48'd1);
    if (n == 48) check(rx[23:0] == tx[47:24], "R4 echo", 48'(rx[23:0]), 48'(tx[47:24]));
    if (n == 24 || n == 48) begin
      w = 24'(tx >> (48 - n));
      out_m = w[15:0];
      pd_m  = w[16];
    end
    wait_clk(30);
    check(out_en == out_m, (n % 24 == 0) ? "R1 R6 out latch" : "R8 out kept",
          48'(out_en), 48'(out_m));
    check(pd_en == pd_m, (n % 24 == 0) ? "R6 pd latch" : "R8 pd kept",
          48'(pd_en), 48'(pd_m));
    check(miso_oe == 1'b0, "R3 oe idle", 48'(miso_oe), 48'd0);
    check(fault_flags == fexp(raw_open, out_m, pd_m), "R9 gated faults",
          48'(fault_flags), 48'(fexp(raw_open, out_m, pd_m)));
  endtask

  initial begin
    #(20 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] rx;
    int lens [11] = '{24, 48, 24, 48, 24, 48, 23, 25, 1, 47, 36};
    void'($urandom(32'h5eed_0077));
    wait_clk(5);
    rst = 1'b0;
    wait_clk(4);
    // R5 reset state
    check(out_en == '0, "R5 out reset", 48'(out_en), 48'd0);
    check(pd_en == 1'b0, "R5 pd reset", 48'(pd_en), 48'd0);
    check(fault_flags == '0, "R5 fault reset", 48'(fault_flags), 48'd0);
    check(miso_oe == 1'b0, "R5 oe reset", 48'(miso_oe), 48'd0);

    // R9 raw flags without pulldown stay hidden
    raw_open = 16'h00F0;
    wait_clk(6);
    frame({24'h000000, 24'h0}, 24);
    // R6 enable pulldown, all channels off
    frame({24'h010000, 24'h0}, 24);
    // R2 status word now carries the faults
    frame({24'h010000, 24'h0}, 24);
    // R4 echo with distinct words, second word latched
    frame({24'hA5C3_3C, 24'h01_0F0F}, 48);
    // R8 short and long frames leave state alone
    frame({24'h00FFFF, 24'h0}, 23);
    frame({24'h00FFFF, 24'hFFFFFF}, 25);
    frame({24'h0, 24'h0}, 47);
    // R6 reserved bits ignored
    frame({24'hFE0001, 24'h0}, 24);

    // R10 blanking on turning a faulty channel off
    raw_open = 16'h0001;
    frame({24'h010001, 24'h0}, 24);
    spi_xfer({24'h010000, 24'h0}, 24, rx);
    out_m = 16'h0000;
    pd_m  = 1'b1;
    check(fault_flags[0] == 1'b0, "R10 blanked", 48'(fault_flags[0]), 48'd0);
    wait_clk(18);
    check(fault_flags[0] == 1'b1, "R10 after blank", 48'(fault_flags[0]), 48'd1);

    // R7 sleep clears pulldown only
    frame({24'h01ABCD, 24'h0}, 24);
    sleep = 1'b1;
    wait_clk(3);
    sleep = 1'b0;
    pd_m = 1'b0;
    wait_clk(2);
    check(pd_en == 1'b0, "R7 sleep pd", 48'(pd_en), 48'd0);
    check(out_en == out_m, "R7 sleep out", 48'(out_en), 48'(out_m));

    for (int it = 0; it < 40; it++) begin
      logic [47:0] tx;
      int n;
      tx = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      n = lens[$urandom % 11];
      raw_open = 16'($urandom);
      wait_clk(6);
      frame(tx, n);
      if ($urandom % 6 == 0) begin
        sleep = 1'b1;
        wait_clk(2);
        sleep = 1'b0;
        pd_m = 1'b0;
        wait_clk(2);
        check(pd_en == 1'b0 && out_en == out_m, "R7 random sleep",
              48'({pd_en, out_en}), 48'({1'b0, out_m}));
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule